// File: doc/BRIEF.md
# Compare-Status Branch Resolver

This block settles coprocessor conditional branches against the result of the most recent floating-point compare. It keeps a 4-bit relation field that only a retiring compare may write. From that field it derives a 16-bit predicate vector in which every bit is a fixed combination of the relation flags. A decoded branch supplies the low opcode bits and a sub-opcode bit. Together these form an index that picks one predicate bit, and the branch is taken when that bit is 1.

The block also counts how many compares are still in flight. An up/down counter rises when a compare issues and falls when a compare retires or is killed. A compare issued in the shadow of a mispredicted branch can be killed; it then leaves the relation field untouched. While the counter is nonzero a presented branch receives a stall, so the integer pipeline holds the branch until the field is current. A branch presented with the counter at zero is accepted, and one cycle later the block gives a single-cycle result pulse together with the taken flag.

Top module: `cmpbr_resolver`

## Requirements
- R1: After reset the relation field reads 4'b1000 (unordered only), `br_stall` is 0 and `res_valid` and `res_taken` are 0.
- R2: The predicate index is `{br_opc_lo, br_sub}`, with `br_sub` as the least significant bit of the 4-bit index.
- R3: With the field laid out as {unordered[3], greater[2], less[1], equal[0]}, predicate bits are: 0 eq; 1 uno|gt|lt; 2 gt; 3 gt|eq; 4 lt; 5 lt|eq; 6 uno; 7 gt|lt|eq; 8 uno|eq; 9 uno|gt; 10 uno|gt|eq; 11 uno|lt; 12 uno|lt|eq; 13 constant 1.
- R4: Indices 14 and 15 are reserved for other coprocessors and never give a taken result.
- R5: On a cycle with `cmp_retire` high, the relation field takes the value of `cmp_result` at the next clock edge. At no other time does it change.
- R6: A `cmp_kill` pulse removes one pending compare and leaves the relation field unchanged.
- R7: `br_stall` is high exactly when `br_valid` is high and at least one compare is pending. It is low whenever `br_valid` is low.
- R8: A branch that is presented while no compare is pending produces a one-cycle `res_valid` pulse in the next cycle, with `res_taken` equal to the selected predicate bit. A stalled branch produces no pulse, and `res_taken` is 0 whenever `res_valid` is 0.
- R9: When a compare issues in the same cycle that another retires or is killed, the pending count is unchanged. When a retire and a kill fall in the same cycle, the count drops by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_issue | input | 1 | A compare enters the coprocessor pipeline |
| cmp_retire | input | 1 | A compare retires and writes its result |
| cmp_result | input | 4 | Relation flags of the retiring compare {uno, gt, lt, eq} |
| cmp_kill | input | 1 | A pending compare is cancelled without writing |
| br_valid | input | 1 | A coprocessor branch is in its register-read stage |
| br_opc_lo | input | 3 | Low three bits of the branch opcode |
| br_sub | input | 1 | Branch sub-opcode bit |
| br_stall | output | 1 | Hold the branch: a compare is still pending |
| res_valid | output | 1 | One-cycle pulse: a branch was resolved |
| res_taken | output | 1 | Direction of the resolved branch |
| rel_field | output | 4 | Current relation field |

## Verification
The first directed pass retires each single relation flag, and also the all-zero pattern, and then sweeps all sixteen indices. This separates every predicate bit from its neighbours, so it catches a swapped index bit or a wrong OR term. Further directed cases set a high opcode with the sub bit low, and the reverse, to expose index ordering. Other cases kill a compare that carries a conflicting result, and combine an issue with a retire, or a retire with a kill, in one cycle. The stall and field checks show whether a kill wrongly writes the field or whether the count drifts. A long seeded random run mixes issues, retires, kills and branches with multi-flag results, which exercises stall release timing and the reserved indices.

// File: rtl/cmpbr_pkg.sv
// Package: shared constants and the relation-to-predicate mapping.
// Assumes the relation field layout {uno, gt, lt, eq} from bit 3 down to 0.
package cmpbr_pkg;
    localparam int REL_W     = 4;
    localparam int REL_UNO   = 3;
    localparam int REL_GT    = 2;
    localparam int REL_LT    = 1;
    localparam int REL_EQ    = 0;
    localparam int FPU_CONDS = 14;
    localparam logic [REL_W-1:0] REL_RESET = 4'b1000;

    // Returns predicate k for a relation field; k outside the FPU range gives 0.
    function automatic logic cond_of(input logic [REL_W-1:0] rel, input int k);
        logic u, g, l, e;
        u = rel[REL_UNO];
        g = rel[REL_GT];
        l = rel[REL_LT];
        e = rel[REL_EQ];
        case (k)
            0:       cond_of = e;
            1:       cond_of = u | g | l;
            2:       cond_of = g;
            3:       cond_of = g | e;
            4:       cond_of = l;
            5:       cond_of = l | e;
            6:       cond_of = u;
            7:       cond_of = g | l | e;
            8:       cond_of = u | e;
            9:       cond_of = u | g;
            10:      cond_of = u | g | e;
            11:      cond_of = u | l;
            12:      cond_of = u | l | e;
            13:      cond_of = 1'b1;
            default: cond_of = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/cmpbr_pending.sv
// Pending-compare counter: rises on issue, falls on retire and on kill.
// Assumes the pipeline never retires or kills more compares than it issued,
// and never holds more than 2**CNT_W-1 compares.
module cmpbr_pending #(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic retire,
    input  logic kill,
    output logic pending
);
    logic [CNT_W-1:0] cnt_q;

    // Net count update; the three events may coincide in one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_W'(issue) - CNT_W'(retire) - CNT_W'(kill);
    end

    assign pending = (cnt_q != '0);
endmodule

// File: rtl/cmpbr_relreg.sv
// Relation field register: written only by a retiring compare.
// Assumes killed compares never assert the retire strobe.
module cmpbr_relreg
    import cmpbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REL_W-1:0] din,
    output logic [REL_W-1:0] rel
);
    // Hold the last retired compare result; reset reads as unordered.
    always_ff @(posedge clk) begin
        if (!rst_n)  rel <= REL_RESET;
        else if (wr) rel <= din;
    end
endmodule

// File: rtl/cmpbr_predicate.sv
// Predicate vector builder: one combinational bit per branch condition.
// Bits at or above FPU_CONDS are reserved and tied to 0.
module cmpbr_predicate
    import cmpbr_pkg::*;
#(
    parameter int NPRED = 16
) (
    input  logic [REL_W-1:0] rel,
    output logic [NPRED-1:0] vec
);
    for (genvar k = 0; k < NPRED; k++) begin : g_bit
        if (k < FPU_CONDS) begin : g_fpu
            // FPU condition k as a fixed OR of relation flags.
            assign vec[k] = cond_of(rel, k);
        end else begin : g_rsvd
            // Reserved condition slot.
            assign vec[k] = 1'b0;
        end
    end
endmodule

// File: rtl/cmpbr_resolver.sv
// Compare-status branch resolver top.
// Stalls a presented branch while compares are pending, otherwise selects the
// predicate bit {opc_lo, sub} and reports the direction one cycle later.
// Assumes the integer side holds br_valid and the index steady while stalled.
module cmpbr_resolver
    import cmpbr_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int NPRED = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_issue,
    input  logic       cmp_retire,
    input  logic [3:0] cmp_result,
    input  logic       cmp_kill,
    input  logic       br_valid,
    input  logic [2:0] br_opc_lo,
    input  logic       br_sub,
    output logic       br_stall,
    output logic       res_valid,
    output logic       res_taken,
    output logic [3:0] rel_field
);
    localparam int IDX_W = $clog2(NPRED);

    logic             pending;
    logic [NPRED-1:0] pred_vec;
    logic [IDX_W-1:0] sel_idx;
    logic             accept;

    cmpbr_pending #(.CNT_W(CNT_W)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (cmp_issue),
        .retire (cmp_retire),
        .kill   (cmp_kill),
        .pending(pending)
    );

    cmpbr_relreg u_rel (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (cmp_retire),
        .din  (cmp_result),
        .rel  (rel_field)
    );

    cmpbr_predicate #(.NPRED(NPRED)) u_pred (
        .rel(rel_field),
        .vec(pred_vec)
    );

    // Index: opcode low bits above, sub-opcode bit as LSB.
    assign sel_idx  = {br_opc_lo, br_sub};
    assign br_stall = br_valid & pending;
    assign accept   = br_valid & ~pending;

    // Register the resolution pulse and its direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_taken <= 1'b0;
        end else begin
            res_valid <= accept;
            res_taken <= accept & pred_vec[sel_idx];
        end
    end
endmodule

// File: rtl/cmpbr_checker.sv
// Assertion checker for cmpbr_resolver, attached by bind below.
module cmpbr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmp_retire,
    input logic [3:0] cmp_result,
    input logic       br_valid,
    input logic [2:0] br_opc_lo,
    input logic       br_sub,
    input logic       br_stall,
    input logic       res_valid,
    input logic       res_taken
);
    // R5: a retire loads the result at the next edge.
    a_r5_retire_loads: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_retire |=> (cmpbr_resolver.rel_field == $past(cmp_result)));

    // R5, R6: without a retire the field holds.
    a_r6_field_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_retire |=> $stable(cmpbr_resolver.rel_field));

    // R7: no stall without a branch.
    a_r7_stall_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
        br_stall |-> br_valid);

    // R8: a result pulse follows an accepted branch only.
    a_r8_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(br_valid && !br_stall));

    // R8: taken only with a pulse.
    a_r8_taken_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_taken);

    // R4: reserved indices never taken.
    a_r4_reserved_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !br_stall && br_opc_lo == 3'b111) |=> !res_taken);
endmodule

bind cmpbr_resolver cmpbr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_retire(cmp_retire),
    .cmp_result(cmp_result),
    .br_valid  (br_valid),
    .br_opc_lo (br_opc_lo),
    .br_sub    (br_sub),
    .br_stall  (br_stall),
    .res_valid (res_valid),
    .res_taken (res_taken)
);

// File: tb/tb_cmpbr_resolver.sv
module tb_cmpbr_resolver;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmp_issue, cmp_retire, cmp_kill, br_valid, br_sub;
    logic [3:0] cmp_result;
    logic [2:0] br_opc_lo;
    logic       br_stall, res_valid, res_taken;
    logic [3:0] rel_field;

    int n_chk = 0;
    int n_bad = 0;
    int m_cnt = 0;
    logic [3:0] m_rel = 4'b1000;

    always #10 clk = ~clk;

    cmpbr_resolver dut (
        .clk(clk), .rst_n(rst_n),
        .cmp_issue(cmp_issue), .cmp_retire(cmp_retire),
        .cmp_result(cmp_result), .cmp_kill(cmp_kill),
        .br_valid(br_valid), .br_opc_lo(br_opc_lo), .br_sub(br_sub),
        .br_stall(br_stall), .res_valid(res_valid),
        .res_taken(res_taken), .rel_field(rel_field)
    );

    // Expected predicate from the R3/R4 table, field {uno, gt, lt, eq}.
    function automatic logic exp_pred(input logic [3:0] r, input int i);
        logic u, g, l, e;
        {u, g, l, e} = r;
        case (i)
            0: return e;           1: return u | g | l;
            2: return g;           3: return g | e;
            4: return l;           5: return l | e;
            6: return u;           7: return g | l | e;
            8: return u | e;       9: return u | g;
            10: return u | g | e;  11: return u | l;
            12: return u | l | e;  13: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check stall, clock, check registered outputs.
    task automatic step(input logic iss, input logic ret, input logic [3:0] res,
                        input logic kil, input logic bv, input logic [3:0] idx);
        logic e_rv, e_tk;
        @(negedge clk);
        cmp_issue = iss; cmp_retire = ret; cmp_result = res; cmp_kill = kil;
        br_valid = bv; {br_opc_lo, br_sub} = idx;
        #2;
        check("R7 stall", br_stall, bv && (m_cnt != 0));
        e_rv = bv && (m_cnt == 0);
        e_tk = e_rv && exp_pred(m_rel, int'(idx));
        m_cnt = m_cnt + int'(iss) - int'(ret) - int'(kil);
        if (ret) m_rel = res;
        @(posedge clk);
        #2;
        check("R8 res_valid", res_valid, e_rv);
        check(idx >= 14 ? "R4 reserved taken" : "R2/R3 res_taken", res_taken, e_tk);
        check("R5/R6 rel_field", rel_field, m_rel);
    endtask

    task automatic idle();
        step(0, 0, 4'h0, 0, 0, 4'h0);
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cmp_issue = 0; cmp_retire = 0; cmp_result = 0; cmp_kill = 0;
        br_valid = 0; br_opc_lo = 0; br_sub = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 rel_field", rel_field, 4'b1000);
        check("R1 res_valid", res_valid, 0);
        check("R1 res_taken", res_taken, 0);
        check("R1 stall", br_stall, 0);
        @(negedge clk);
        rst_n = 1;

        // R1: the reset field resolves as unordered.
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 1, 4'(i));

        // R3: each single flag, then zero, swept over all indices.
        foreach (m_rel[b]) begin end
        for (int f = 0; f < 5; f++) begin
            logic [3:0] v;
            v = (f < 4) ? 4'(1 << f) : 4'h0;
            step(1, 0, 0, 0, 0, 0);
            step(0, 1, v, 0, 1, 4'h0);
            for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 1, 4'(i));
        end

        // R2: opcode high with sub low vs. the reverse (field = equal).
        step(1, 0, 0, 0, 0, 0);
        step(0, 1, 4'b0001, 0, 0, 0);
        step(0, 0, 0, 0, 1, {3'b000, 1'b1});
        step(0, 0, 0, 0, 1, {3'b001, 1'b0});
        step(0, 0, 0, 0, 1, {3'b100, 1'b0});

        // R6: killed compare with a conflicting result leaves the field.
        step(1, 0, 0, 0, 1, 4'd0);
        step(0, 0, 4'b1000, 1, 1, 4'd0);
        step(0, 0, 0, 0, 1, 4'd6);

        // R9: issue with retire, then retire with kill.
        step(1, 0, 0, 0, 0, 0);
        step(1, 1, 4'b0100, 0, 1, 4'd2);
        step(1, 0, 0, 0, 1, 4'd2);
        step(0, 1, 4'b0010, 1, 1, 4'd4);
        step(0, 0, 0, 0, 1, 4'd4);

        // Random mix with a fixed seed; R4, R7, R8 exercised throughout.
        void'($urandom(32'd2024));
        for (int c = 0; c < 4000; c++) begin
            logic iss, ret, kil;
            iss = (m_cnt < 6) && ($urandom_range(0, 2) == 0);
            ret = (m_cnt >= 1) && ($urandom_range(0, 2) == 0);
            kil = (m_cnt >= (ret ? 2 : 1)) && ($urandom_range(0, 5) == 0);
            step(iss, ret, 4'($urandom), kil, $urandom_range(0, 1) == 1,
                 4'($urandom));
        end
        while (m_cnt > 0) step(0, 1, 4'($urandom), 0, 0, 0);
        idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule